// File: doc/BRIEF.md
# Slow-Clock Real-Time Timer with Alarm

This block is a free-running seconds-style timer for a peripheral bus. A programmable divider counts cycles of the slow clock that drives the block. Each time the divider completes a period, a 32-bit up-counter advances by one. Software cannot load the counter. It can only zero the counter, together with the divider, through a restart bit in the mode register. A 32-bit alarm register is compared against the counter as it advances. An alarm value of all ones is the convention for "no alarm armed".

Two sticky event flags record alarm matches and counter increments. Reading the status word returns both flags and clears them in the same access. A single level-sensitive interrupt line is raised while any flag is set whose enable bit is on. The register bus is a one-cycle select/write strobe with a word index. Read data is combinational during the access cycle.

Top module: `rtalarm_timer`

## Requirements
- R1: After the synchronous active-low reset, the mode word reads 0x0000_8000, the alarm word reads 0xFFFF_FFFF, the counter reads 0, the status reads 0 and `irq` is low.
- R2: The mode word (word index 0) holds the divider value in bits [15:0], the alarm interrupt enable in bit 16, the increment interrupt enable in bit 17 and a restart command in bit 18. Bits [17:0] read back as written. Bit 18 and all higher bits always read 0.
- R3: With a nonzero divider value P, the counter advances by exactly one every P clock cycles. With P = 0 the counter holds its value.
- R4: A mode write with bit 18 set zeroes the counter and the divider. The first increment after it then lands exactly P cycles after the write edge.
- R5: Writes to the counter word (index 2) and the status word (index 3) change neither of them.
- R6: Status bit 1 is set on every counter increment.
- R7: Status bit 0 is set only on the increment that makes the counter equal to the alarm word (index 1). It is not set again in later cycles while the counter stays equal to the alarm.
- R8: A read of the status word returns both flags and clears them at the end of that access.
- R9: An event arriving in the same cycle as a status read is kept set, not lost to the clear.
- R10: `irq` is high exactly while (status bit 0 and mode bit 16) or (status bit 1 and mode bit 17).
- R11: The alarm word reads back all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; also clocks the register bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Word index: 0 mode, 1 alarm, 2 counter, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, valid in the access cycle |
| irq | output | 1 | Level interrupt request |

## Verification
Several boundary cases get directed tests.

- **Divider length.** The bench sweeps divider values, including 1, 0 and values that do not divide the wait evenly. An off-by-one divider shows up as the wrong count. A divider that does not halt on zero counts when it should not.
- **Restart alignment.** Restart alignment is checked by timing the first increment after a restart. A divider that is not cleared, or a tick that escapes on the restart edge, shifts that increment.
- **Status read racing an event.** A status read is placed on the exact edge of an increment. A design that lets the clear win would lose the flag.
- **Alarm held across cycles.** The counter is left resting on the alarm value after a read has cleared the flag. A level-compare alarm would set the flag again.
- **Interrupt masking.** The interrupt is checked with an enabled flag and with a masked flag.

// File: rtl/rtalarm_pkg.sv
package rtalarm_pkg;
   typedef enum logic [1:0] {
      WORD_MODE   = 2'd0,
      WORD_ALARM  = 2'd1,
      WORD_COUNT  = 2'd2,
      WORD_STATUS = 2'd3
   } word_sel_e;

   localparam int unsigned ST_ALARM_IDX = 0;
   localparam int unsigned ST_INC_IDX   = 1;
   localparam int unsigned ST_W         = 2;
endpackage

// File: rtl/rtalarm_prescaler.sv
module rtalarm_prescaler #(
   parameter int unsigned PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] presc,
   input  logic             restart,
   output logic             tick
);
   logic [PRE_W-1:0] div_q;
   logic             running;
   logic [PRE_W-1:0] last_val;

   assign running  = (presc != '0);
   assign last_val = presc - PRE_W'(1);
   assign tick     = running && (div_q >= last_val) && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (restart || tick) begin
         div_q <= '0;
      end else if (running) begin
         div_q <= div_q + PRE_W'(1);
      end
   end

   // R3
   presc_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (presc == '0 && !restart) |=> $stable(div_q));
endmodule

// File: rtl/rtalarm_counter.sv
module rtalarm_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] alarm,
   output logic [CNT_W-1:0] count,
   output logic             alarm_hit
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt   = cnt_q + CNT_W'(1);
   assign alarm_hit = tick && (cnt_nxt == alarm);
   assign count     = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_nxt;
      end
   end

   // R4
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(restart) && cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/rtalarm_regs.sv
module rtalarm_regs
   import rtalarm_pkg::*;
#(
   parameter int unsigned        PRE_W     = 16,
   parameter int unsigned        CNT_W     = 32,
   parameter int unsigned        DATA_W    = 32,
   parameter logic [PRE_W-1:0]   RST_PRESC = 16'h8000,
   parameter bit                 IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_word,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              tick,
   input  logic              alarm_hit,
   output logic [PRE_W-1:0]  presc,
   output logic [CNT_W-1:0]  alarm,
   output logic              restart,
   output logic              irq
);
   localparam int unsigned EN_ALM_BIT  = PRE_W;
   localparam int unsigned EN_INC_BIT  = PRE_W + 1;
   localparam int unsigned RESTART_BIT = PRE_W + 2;

   word_sel_e        sel;
   logic             wr_mode, wr_alarm, rd_status;
   logic             en_alm_q, en_inc_q;
   logic [PRE_W-1:0] presc_q;
   logic [CNT_W-1:0] alarm_q;
   logic [ST_W-1:0]  status_q, ev, status_nxt;
   logic             irq_c;

   assign sel       = word_sel_e'(bus_word);
   assign wr_mode   = bus_sel && bus_wr && (sel == WORD_MODE);
   assign wr_alarm  = bus_sel && bus_wr && (sel == WORD_ALARM);
   assign rd_status = bus_sel && !bus_wr && (sel == WORD_STATUS);
   assign restart   = wr_mode && bus_wdata[RESTART_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         presc_q  <= RST_PRESC;
         en_alm_q <= 1'b0;
         en_inc_q <= 1'b0;
      end else if (wr_mode) begin
         presc_q  <= bus_wdata[PRE_W-1:0];
         en_alm_q <= bus_wdata[EN_ALM_BIT];
         en_inc_q <= bus_wdata[EN_INC_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= '1;
      end else if (wr_alarm) begin
         alarm_q <= bus_wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      ev               = '0;
      ev[ST_ALARM_IDX] = alarm_hit;
      ev[ST_INC_IDX]   = tick;
      status_nxt       = (rd_status ? '0 : status_q) | ev;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_nxt;
   end

   assign irq_c = (status_q[ST_ALARM_IDX] && en_alm_q) ||
                  (status_q[ST_INC_IDX]   && en_inc_q);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_c;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_c;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         WORD_MODE: begin
            bus_rdata[PRE_W-1:0] = presc_q;
            bus_rdata[EN_ALM_BIT] = en_alm_q;
            bus_rdata[EN_INC_BIT] = en_inc_q;
         end
         WORD_ALARM:  bus_rdata[CNT_W-1:0] = alarm_q;
         WORD_COUNT:  bus_rdata[CNT_W-1:0] = count;
         WORD_STATUS: bus_rdata[ST_W-1:0]  = status_q;
         default:     bus_rdata = '0;
      endcase
   end

   assign presc = presc_q;
   assign alarm = alarm_q;

   // R8
   st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !tick && !alarm_hit) |=> (status_q == '0));

   // R9
   inc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> status_q[ST_INC_IDX]);

   // R7
   alarm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> status_q[ST_ALARM_IDX]);
endmodule

// File: rtl/rtalarm_timer.sv
module rtalarm_timer #(
   parameter int unsigned      PRE_W     = 16,
   parameter int unsigned      CNT_W     = 32,
   parameter logic [PRE_W-1:0] RST_PRESC = 16'h8000,
   parameter bit               IRQ_REG   = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [1:0]  bus_word,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);
   localparam int unsigned DATA_W = 32;

   generate
      if (PRE_W < 1 || PRE_W + 3 > DATA_W) begin : g_bad_pre
         $error("PRE_W must leave room for three mode bits");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must fit the data bus");
      end
   endgenerate

   logic [PRE_W-1:0] presc;
   logic [CNT_W-1:0] alarm, count;
   logic             restart, tick, alarm_hit;

   rtalarm_regs #(
      .PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
      .RST_PRESC(RST_PRESC), .IRQ_REG(IRQ_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count(count), .tick(tick), .alarm_hit(alarm_hit),
      .presc(presc), .alarm(alarm), .restart(restart), .irq(irq)
   );

   rtalarm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .presc(presc), .restart(restart), .tick(tick)
   );

   rtalarm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
      .alarm(alarm), .count(count), .alarm_hit(alarm_hit)
   );
endmodule

// File: tb/rtalarm_timer_test.sv
module rtalarm_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_word = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [31:0] RESTART = 32'h0004_0000;
   localparam int VEC_N = 7;
   localparam logic [15:0] V_PRE [VEC_N]  = '{16'd1, 16'd2, 16'd3, 16'd5, 16'd7, 16'd4, 16'd0};
   localparam int          V_WAIT [VEC_N] = '{10, 9, 12, 14, 6, 40, 25};

   always #10 clk = ~clk;

   rtalarm_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // both tasks start and end at a falling edge
   task automatic bwrite(input logic [1:0] w, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [1:0] w, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_word = w;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      bread(2'd0, d); check("R1 mode", d, 32'h0000_8000);
      bread(2'd1, d); check("R1 alarm", d, 32'hFFFF_FFFF);
      bread(2'd2, d); check("R1 count", d, 32'd0);
      bread(2'd3, d); check("R1 status", d, 32'd0);

      // R2 readback, restart bit and upper bits read 0
      bwrite(2'd0, 32'hFFFF_FFFF);
      bread(2'd0, d); check("R2 mode readback", d, 32'h0003_FFFF);
      bwrite(2'd0, 32'h0001_A5A5);
      bread(2'd0, d); check("R2 mode pattern", d, 32'h0001_A5A5);

      // R11 alarm readback
      bwrite(2'd1, 32'h1234_5678);
      bread(2'd1, d); check("R11 alarm", d, 32'h1234_5678);

      // R5 counter and status are not writable (divider large, no events)
      bwrite(2'd0, RESTART | 32'h0000_FFFF);
      bwrite(2'd2, 32'hDEAD_BEEF);
      bread(2'd2, d); check("R5 count write ignored", d, 32'd0);
      bwrite(2'd3, 32'h0000_0003);
      bread(2'd3, d); check("R5 status write ignored", d, 32'd0);

      // R3 R4 divider table: restart, wait, counter = wait / P (held when P = 0)
      for (int i = 0; i < VEC_N; i++) begin
         bwrite(2'd0, RESTART | {16'd0, V_PRE[i]});
         repeat (V_WAIT[i]) @(negedge clk);
         bread(2'd2, d);
         check($sformatf("R3 R4 P=%0d wait=%0d", V_PRE[i], V_WAIT[i]), d,
               (V_PRE[i] == 16'd0) ? 32'd0 : 32'(V_WAIT[i] / int'(V_PRE[i])));
      end

      // R6 R8 R9 R10: P=3, increment irq enabled; increments at edges 3, 6, 9
      bwrite(2'd0, RESTART | 32'h0002_0003);
      repeat (3) @(negedge clk);
      check("R10 irq on enabled increment", {31'd0, irq}, 32'd1);
      bread(2'd3, d); check("R6 increment flag", d, 32'd2);
      bread(2'd3, d); check("R8 cleared by read", d, 32'd0);
      check("R10 irq low after clear", {31'd0, irq}, 32'd0);
      bread(2'd3, d); check("R8 still clear", d, 32'd0);
      bread(2'd3, d); check("R9 event during read kept", d, 32'd2);

      // R7 R10: alarm at 2, P=2, alarm irq only; increments at edges 2, 4, 6
      bwrite(2'd1, 32'd2);
      bwrite(2'd0, RESTART | 32'h0001_0002);
      bread(2'd3, d);
      repeat (3) @(negedge clk);
      check("R10 irq on alarm", {31'd0, irq}, 32'd1);
      bread(2'd3, d); check("R7 alarm and increment", d, 32'd3);
      bread(2'd3, d); check("R7 no repeat while equal", d, 32'd0);
      check("R10 increment masked", {31'd0, irq}, 32'd0);
      bread(2'd3, d); check("R7 later increment only", d, 32'd2);
      bread(2'd2, d); check("R3 count after alarm", d, 32'd3);

      finish_run();
   end
endmodule